// File: doc/BRIEF.md
# Multiply-step and divide unit

This unit executes the integer multiply and divide operations of a 32-bit processor pipeline. It works alongside a 32-bit Y register that the surrounding core keeps. Y is presented on `y_in`, and the value Y should take after the operation is returned on `y_out`. The multiply operations and the single multiply step finish in one clock cycle. A full multiply places the high product word in Y. A multiply step shifts one partial-product bit through Y, so that a software loop of such steps forms a product.

Divide treats Y as the upper word of a 64-bit dividend and the first operand as its lower word. A sequencer then produces one quotient bit per cycle. A quotient too large for 32 bits is clamped to the largest value that can be represented, and the overflow flag is raised. A zero divisor is reported at once and no iteration runs. The core pulses `start` with an operation code and watches `done`. `busy` stays high while a divide is in progress, and a `start` during that time is discarded.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, `result`, `y_out` and `nzvc` are zero, and `done`, `busy` and `div_zero` are low.
- R2: Operation code 0 (multiply step) forms `{n_in ^ v_in, opa[31:1]}`. It adds `opb` to that value when `y_in[0]` is 1 and adds zero when `y_in[0]` is 0, and returns the sum on `result`. It returns `{opa[0], y_in[31:1]}` on `y_out`.
- R3: The flags on `nzvc` are packed as N in bit 3, Z in bit 2, V in bit 1 and C in bit 0. For the multiply step they are those of the addition: C is the carry out and V is the signed overflow. For every completed operation other than a zero-divisor report, N equals `result[31]` and Z is set when `result` is zero.
- R4: Operation code 1 (unsigned multiply) zero-extends both operands. It returns the low product word on `result` and the high word on `y_out`, with V and C cleared.
- R5: Operation code 2 (signed multiply) sign-extends both operands, with the same placement of the product words and the same flag rules as R4.
- R6: For codes 0, 1 and 2, `done` is high in the cycle after the edge that accepted `start`, and `busy` stays low.
- R7: Operation code 3 (unsigned divide) divides `{y_in, opa}` by `opb`. `busy` is high from the cycle after acceptance, and `done` rises, with `busy` falling, 33 cycles (DW+1) after the accepting edge.
- R8: An unsigned quotient above 0xFFFFFFFF gives `result` = 0xFFFFFFFF with V set.
- R9: Operation code 4 (signed divide) divides the two's-complement dividend `{y_in, opa}` by the signed `opb` and truncates toward zero. A quotient above 0x7FFFFFFF gives 0x7FFFFFFF, and one below -2^31 gives 0x80000000. In both cases V is set, and -2^31 itself is not clamped.
- R10: After a divide, V reports the clamp, C is zero, and `y_out` keeps the value it had before the divide.
- R11: A divide whose `opb` is zero raises `div_zero` together with `done` one cycle after acceptance. `busy` is never raised, and `result`, `y_out` and `nzvc` keep their previous values.
- R12: A `start` while `busy` is high is ignored. The running divide finishes with its own quotient and timing, and no extra `done` or `div_zero` appears.
- R13: Operation codes 5 to 7 are ignored. `done` stays low and all outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Operation request, sampled on the rising edge |
| op | input | 3 | Operation code (0 step, 1 unsigned mul, 2 signed mul, 3 unsigned div, 4 signed div) |
| opa | input | 32 | First operand; low dividend word for divide |
| opb | input | 32 | Second operand; divisor for divide |
| y_in | input | 32 | Current Y value; high dividend word for divide |
| n_in | input | 1 | Incoming negative flag |
| v_in | input | 1 | Incoming overflow flag |
| result | output | 32 | Operation result |
| y_out | output | 32 | Updated Y value |
| nzvc | output | 4 | New flags N, Z, V, C (bits 3 down to 0) |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Divide in progress |
| div_zero | output | 1 | Divide requested with a zero divisor |

## Verification
The hardest cases to reach are the signed clamp boundaries, because they require a particular 64-bit dividend. The stimulus uses Y = 0xFFFFFFFF with a low word of 0x80000000 divided by one, which gives exactly -2^31 and must pass through unclamped. Moving the low word to 0x7FFFFFFF gives -2^31-1, which must clamp. It also sets a high dividend word at or above the divisor, so that the clamp is decided before any iteration runs. A further case overlaps requests: a multiply and a zero-divisor divide are issued in the middle of a running divide. The bench then counts completion pulses to show that neither request changes the quotient or its timing.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [2:0] {
    OP_MSTEP = 3'd0,
    OP_UMUL  = 3'd1,
    OP_SMUL  = 3'd2,
    OP_UDIV  = 3'd3,
    OP_SDIV  = 3'd4
  } md_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } ccode_t;
endpackage

// File: rtl/md_mul_path.sv
module md_mul_path
  import muldiv_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          sgn,
  input  logic          step,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [DW-1:0] y_in,
  input  logic          n_in,
  input  logic          v_in,
  output logic [DW-1:0] res,
  output logic [DW-1:0] y_new,
  output ccode_t        cc
);
  localparam int PW = 2 * DW;

  logic [PW-1:0] ax, bx, prod;
  logic [DW-1:0] shifted, addend;
  logic [DW:0]   sum;

  always_comb begin
    ax   = {{DW{sgn & a[DW-1]}}, a};
    bx   = {{DW{sgn & b[DW-1]}}, b};
    prod = ax * bx;

    shifted = {n_in ^ v_in, a[DW-1:1]};
    addend  = y_in[0] ? b : '0;
    sum     = {1'b0, shifted} + {1'b0, addend};

    if (step) begin
      res   = sum[DW-1:0];
      y_new = {a[0], y_in[DW-1:1]};
      cc.n  = sum[DW-1];
      cc.z  = ~|sum[DW-1:0];
      cc.c  = sum[DW];
      cc.v  = ~(shifted[DW-1] ^ addend[DW-1]) & (shifted[DW-1] ^ sum[DW-1]);
    end else begin
      res   = prod[DW-1:0];
      y_new = prod[PW-1:DW];
      cc.n  = prod[DW-1];
      cc.z  = ~|prod[DW-1:0];
      cc.c  = 1'b0;
      cc.v  = 1'b0;
    end
  end
endmodule

// File: rtl/md_div_seq.sv
module md_div_seq #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          sgn,
  input  logic [DW-1:0] hi,
  input  logic [DW-1:0] lo,
  input  logic [DW-1:0] dsr,
  output logic          busy,
  output logic          fin,
  output logic [DW-1:0] quot,
  output logic          sat
);
  localparam int          CW   = $clog2(DW);
  localparam int          PW   = 2 * DW;
  localparam logic [CW-1:0] LAST = CW'(DW - 1);
  localparam logic [DW-1:0] MAXP = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] MINN = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] ONES = '1;

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] rem_q, rem_d, quo_q, quo_d, dsr_q, dsr_d;
  logic          negq_q, negq_d, sgn_q, sgn_d, pre_q, pre_d;
  logic          en;

  logic [PW-1:0] dvd, dmag;
  logic [DW-1:0] bmag, rem_sub;
  logic [DW:0]   trial;
  logic          ge, qovf;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    rem_d  = rem_q;
    quo_d  = quo_q;
    dsr_d  = dsr_q;
    negq_d = negq_q;
    sgn_d  = sgn_q;
    pre_d  = pre_q;
    fin    = 1'b0;
    quot   = '0;
    sat    = 1'b0;
    qovf   = 1'b0;

    dvd   = {hi, lo};
    dmag  = (sgn & hi[DW-1]) ? -dvd : dvd;
    bmag  = (sgn & dsr[DW-1]) ? -dsr : dsr;

    trial   = {rem_q, quo_q[DW-1]};
    ge      = trial >= {1'b0, dsr_q};
    rem_sub = DW'(trial - {1'b0, dsr_q});

    if (go) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      rem_d  = dmag[PW-1:DW];
      quo_d  = dmag[DW-1:0];
      dsr_d  = bmag;
      sgn_d  = sgn;
      negq_d = sgn & (hi[DW-1] ^ dsr[DW-1]);
      pre_d  = dmag[PW-1:DW] >= bmag;
    end else if (busy_q) begin
      rem_d = ge ? rem_sub : trial[DW-1:0];
      quo_d = {quo_q[DW-2:0], ge};
      cnt_d = cnt_q + CW'(1);
      if (cnt_q == LAST) begin
        busy_d = 1'b0;
        fin    = 1'b1;
        if (sgn_q) begin
          qovf = pre_q | (negq_q ? (quo_d > MINN) : (quo_d > MAXP));
          sat  = qovf;
          if (qovf) quot = negq_q ? MINN : MAXP;
          else      quot = negq_q ? -quo_d : quo_d;
        end else begin
          sat  = pre_q;
          quot = pre_q ? ONES : quo_d;
        end
      end
    end
  end

  assign en   = go | busy_q;
  assign busy = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      dsr_q  <= '0;
      negq_q <= 1'b0;
      sgn_q  <= 1'b0;
      pre_q  <= 1'b0;
    end else if (en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      dsr_q  <= dsr_d;
      negq_q <= negq_d;
      sgn_q  <= sgn_d;
      pre_q  <= pre_d;
    end
  end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    op,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic [DW-1:0] y_in,
  input  logic          n_in,
  input  logic          v_in,
  output logic [DW-1:0] result,
  output logic [DW-1:0] y_out,
  output logic [3:0]    nzvc,
  output logic          done,
  output logic          busy,
  output logic          div_zero
);
  logic [1:0] rsync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  logic          is_mul, is_div, acc, mul_acc, div_go, dz_hit;
  logic          d_busy, d_fin, d_sat;
  logic [DW-1:0] d_quot, m_res, m_y;
  ccode_t        m_cc;

  assign is_mul  = (op == OP_MSTEP) | (op == OP_UMUL) | (op == OP_SMUL);
  assign is_div  = (op == OP_UDIV) | (op == OP_SDIV);
  assign acc     = start & ~d_busy;
  assign mul_acc = acc & is_mul;
  assign dz_hit  = acc & is_div & ~|opb;
  assign div_go  = acc & is_div & |opb;

  md_mul_path #(.DW(DW)) u_mul (
    .sgn   (op == OP_SMUL),
    .step  (op == OP_MSTEP),
    .a     (opa),
    .b     (opb),
    .y_in  (y_in),
    .n_in  (n_in),
    .v_in  (v_in),
    .res   (m_res),
    .y_new (m_y),
    .cc    (m_cc)
  );

  md_div_seq #(.DW(DW)) u_div (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .go    (div_go),
    .sgn   (op == OP_SDIV),
    .hi    (y_in),
    .lo    (opa),
    .dsr   (opb),
    .busy  (d_busy),
    .fin   (d_fin),
    .quot  (d_quot),
    .sat   (d_sat)
  );

  logic [DW-1:0] res_q, res_d, y_q, y_d;
  ccode_t        cc_q, cc_d;
  logic          done_q, done_d, dz_q, dz_d, upd;

  always_comb begin
    res_d  = res_q;
    y_d    = y_q;
    cc_d   = cc_q;
    done_d = 1'b0;
    dz_d   = 1'b0;
    upd    = 1'b0;
    if (mul_acc) begin
      res_d  = m_res;
      y_d    = m_y;
      cc_d   = m_cc;
      done_d = 1'b1;
      upd    = 1'b1;
    end else if (dz_hit) begin
      done_d = 1'b1;
      dz_d   = 1'b1;
    end else if (d_fin) begin
      res_d  = d_quot;
      cc_d.n = d_quot[DW-1];
      cc_d.z = ~|d_quot;
      cc_d.v = d_sat;
      cc_d.c = 1'b0;
      done_d = 1'b1;
      upd    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_q  <= '0;
      y_q    <= '0;
      cc_q   <= '0;
      done_q <= 1'b0;
      dz_q   <= 1'b0;
    end else begin
      done_q <= done_d;
      dz_q   <= dz_d;
      if (upd) begin
        res_q <= res_d;
        y_q   <= y_d;
        cc_q  <= cc_d;
      end
    end
  end

  assign result   = res_q;
  assign y_out    = y_q;
  assign nzvc     = cc_q;
  assign done     = done_q;
  assign busy     = d_busy;
  assign div_zero = dz_q;
endmodule

// File: rtl/muldiv_chk.sv
module muldiv_chk
  import muldiv_pkg::*;
#(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [2:0]    op,
  input logic [DW-1:0] opb,
  input logic [DW-1:0] result,
  input logic [3:0]    nzvc,
  input logic          done,
  input logic          busy,
  input logic          div_zero
);
  localparam logic [DW-1:0] MAXP = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] MINN = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] ONES = '1;

  logic req_mul, req_div, req_rsv;
  assign req_mul = start & ~busy & (op <= 3'd2);
  assign req_div = start & ~busy & ((op == OP_UDIV) | (op == OP_SDIV));
  assign req_rsv = start & ~busy & (op > 3'd4);

  AST_MUL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_mul |=> (done && !div_zero && !busy)); // R6
  AST_ZERO_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_div && opb == '0) |=> (done && div_zero && !busy)); // R11
  AST_DZ_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    div_zero |-> done); // R11
  AST_DIV_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_div && opb != '0) |=> (busy && !done)); // R7
  AST_NO_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done); // R12
  AST_RES_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(result)); // R12
  AST_DIV_CARRY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(busy)) |-> !nzvc[0]); // R10
  AST_SAT_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(busy) && nzvc[1]) |-> (result == ONES || result == MAXP || result == MINN)); // R8
  AST_ZN_FROM_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_zero) |-> (nzvc[2] == (result == '0) && nzvc[3] == result[DW-1])); // R3
  AST_RESERVED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_rsv |=> !done); // R13
endmodule

bind muldiv_unit muldiv_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .start    (start),
  .op       (op),
  .opb      (opb),
  .result   (result),
  .nzvc     (nzvc),
  .done     (done),
  .busy     (busy),
  .div_zero (div_zero)
);

// File: tb/sim_muldiv_unit.sv
module sim_muldiv_unit;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_LAT    = 33;

  logic        clk, rst_n, start, n_in, v_in;
  logic [2:0]  op;
  logic [31:0] opa, opb, y_in;
  logic [31:0] result, y_out;
  logic [3:0]  nzvc;
  logic        done, busy, div_zero;

  int checks = 0;
  int errors = 0;
  logic [31:0] e_res, e_y;
  logic [3:0]  e_cc;

  muldiv_unit u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .opa(opa), .opb(opb),
    .y_in(y_in), .n_in(n_in), .v_in(v_in), .result(result), .y_out(y_out),
    .nzvc(nzvc), .done(done), .busy(busy), .div_zero(div_zero)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic run(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b,
                     input logic [31:0] yy, input logic n, input logic v,
                     output int lat, output logic first_busy);
    @(negedge clk);
    start = 1'b1; op = o; opa = a; opb = b; y_in = yy; n_in = n; v_in = v;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    first_busy = busy;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic t_reset;
    chk("R1", "result", result, 0);
    chk("R1", "y_out", y_out, 0);
    chk("R1", "nzvc", nzvc, 0);
    chk("R1", "done/busy/div_zero", {done, busy, div_zero}, 0);
    e_res = 0; e_y = 0; e_cc = 0;
  endtask

  task automatic t_mstep(input logic [31:0] a, input logic [31:0] b, input logic [31:0] yy,
                         input logic n, input logic v);
    int lat; logic fb;
    logic [31:0] sh, add;
    logic [63:0] us;
    longint ss;
    logic [31:0] r;
    logic ov;
    sh  = {n ^ v, a[31:1]};
    add = yy[0] ? b : 32'h0;
    us  = {32'h0, sh} + {32'h0, add};
    ss  = longint'($signed(sh)) + longint'($signed(add));
    ov  = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
    r   = us[31:0];
    run(3'd0, a, b, yy, n, v, lat, fb);
    chk("R6", "step latency", lat, 1);
    chk("R2", "step result", result, r);
    chk("R2", "step y_out", y_out, {a[0], yy[31:1]});
    chk("R3", "step flags", nzvc, {r[31], r == 0, ov, us[32]});
    e_res = r; e_y = {a[0], yy[31:1]}; e_cc = {r[31], r == 0, ov, us[32]};
  endtask

  task automatic t_mul(input logic sgn, input logic [31:0] a, input logic [31:0] b);
    int lat; logic fb;
    logic [63:0] p;
    string tag;
    tag = sgn ? "R5" : "R4";
    if (sgn) p = longint'($signed(a)) * longint'($signed(b));
    else     p = {32'h0, a} * {32'h0, b};
    run(sgn ? 3'd2 : 3'd1, a, b, 32'h1234_5678, 1'b1, 1'b0, lat, fb);
    chk("R6", "mul latency/busy", {lat[7:0], fb}, {8'd1, 1'b0});
    chk(tag, "mul low", result, p[31:0]);
    chk(tag, "mul high", y_out, p[63:32]);
    chk(tag, "mul flags", nzvc, {p[31], p[31:0] == 0, 2'b00});
    e_res = p[31:0]; e_y = p[63:32]; e_cc = {p[31], p[31:0] == 0, 2'b00};
  endtask

  task automatic t_div(input logic sgn, input logic [31:0] a, input logic [31:0] b, input logic [31:0] yy);
    int lat; logic fb;
    logic [63:0] uq;
    longint sq;
    logic [31:0] r;
    logic s;
    string tag;
    if (sgn) begin
      sq = longint'($signed({yy, a})) / longint'($signed(b));
      s  = (sq > 64'sd2147483647) || (sq < -64'sd2147483648);
      r  = s ? ((sq < 0) ? 32'h8000_0000 : 32'h7FFF_FFFF) : sq[31:0];
      tag = "R9";
    end else begin
      uq = {yy, a} / {32'h0, b};
      s  = |uq[63:32];
      r  = s ? 32'hFFFF_FFFF : uq[31:0];
      tag = s ? "R8" : "R7";
    end
    run(sgn ? 3'd4 : 3'd3, a, b, yy, 1'b0, 1'b0, lat, fb);
    chk("R7", "div latency", lat, DIV_LAT);
    chk("R7", "div busy after start", fb, 1);
    chk(tag, "div quotient", result, r);
    chk("R10", "div flags", nzvc, {r[31], r == 0, s, 1'b0});
    chk("R10", "div y_out kept", y_out, e_y);
    e_res = r; e_cc = {r[31], r == 0, s, 1'b0};
  endtask

  task automatic t_divzero(input logic sgn, input logic [31:0] a, input logic [31:0] yy);
    int lat; logic fb;
    run(sgn ? 3'd4 : 3'd3, a, 32'h0, yy, 1'b1, 1'b1, lat, fb);
    chk("R11", "zero-div latency", lat, 1);
    chk("R11", "div_zero/busy", {div_zero, busy}, 2'b10);
    chk("R11", "outputs kept", {result, y_out, nzvc}, {e_res, e_y, e_cc});
  endtask

  task automatic t_busy_ignore;
    int dones = 0;
    int first = 0;
    int dzs = 0;
    @(negedge clk);
    start = 1'b1; op = 3'd3; opa = 32'd1000; opb = 32'd9; y_in = 0;
    @(negedge clk);
    start = 1'b0;
    for (int i = 1; i <= 45; i++) begin
      if (i == 4) begin start = 1'b1; op = 3'd1; opa = 5; opb = 6; end
      if (i == 5) begin op = 3'd3; opb = 0; end
      if (i == 6) start = 1'b0;
      if (done) begin dones++; if (first == 0) first = i; end
      if (div_zero) dzs++;
      @(negedge clk);
    end
    chk("R12", "done count", dones, 1);
    chk("R12", "done cycle", first, DIV_LAT);
    chk("R12", "no div_zero", dzs, 0);
    chk("R12", "quotient", result, 32'd111);
    e_res = 32'd111; e_cc = 4'b0000;
  endtask

  task automatic t_reserved(input logic [2:0] o);
    int dones = 0;
    @(negedge clk);
    start = 1'b1; op = o; opa = 32'hDEAD_BEEF; opb = 3; y_in = 7;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (done) dones++;
      @(negedge clk);
    end
    chk("R13", "reserved done", dones, 0);
    chk("R13", "reserved outputs", {result, y_out, nzvc, busy}, {e_res, e_y, e_cc, 1'b0});
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; op = 0; opa = 0; opb = 0; y_in = 0; n_in = 0; v_in = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_mstep(32'h0000_0003, 32'h0000_0010, 32'h0000_0001, 1'b1, 1'b0);
    t_mstep(32'h1234_5678, 32'hFFFF_FFFF, 32'hABCD_0002, 1'b0, 1'b0);
    t_mstep(32'hFFFF_FFFE, 32'h0000_0001, 32'h0000_0001, 1'b0, 1'b0);
    t_mstep(32'h0000_0000, 32'h8000_0000, 32'h8000_0001, 1'b1, 1'b0);
    t_mul(1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    t_mul(1'b0, 32'h0000_0000, 32'h1234_5678);
    t_mul(1'b1, 32'hFFFF_FFFD, 32'h0000_0005);
    t_mul(1'b1, 32'h8000_0000, 32'h8000_0000);
    t_div(1'b0, 32'd100, 32'd7, 32'h0);
    t_div(1'b0, 32'h0000_0000, 32'd3, 32'h1);
    t_div(1'b0, 32'h0000_0000, 32'd3, 32'h5);
    t_div(1'b1, 32'hFFFF_FF9C, 32'd7, 32'hFFFF_FFFF);
    t_div(1'b1, 32'd100, 32'hFFFF_FFF9, 32'h0);
    t_div(1'b1, 32'h8000_0000, 32'd1, 32'h0);
    t_div(1'b1, 32'h7FFF_FFFF, 32'd1, 32'hFFFF_FFFF);
    t_div(1'b1, 32'h8000_0000, 32'd1, 32'hFFFF_FFFF);
    t_div(1'b1, 32'h0000_0000, 32'd2, 32'h0000_0010);
    t_divzero(1'b0, 32'd55, 32'd0);
    t_divzero(1'b1, 32'd55, 32'hFFFF_FFFF);
    t_busy_ignore;
    t_reserved(3'd5);
    t_reserved(3'd7);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule